// File: doc/BRIEF.md
# Oscillator-Steering PI Loop Filter

This block turns a once-per-second signed timing-error sample into an unsigned code for the DAC that sets an oscillator's tuning voltage. Each accepted sample is first summed with a signed correction value, which lets a late-arriving refinement of the same measurement be folded in before filtering. The sum then passes through a first-order IIR low-pass stage, and a proportional-plus-integral controller acts on the smoothed value. The controller output is added to a programmable centre code and clamped to the DAC range. A one-cycle strobe marks each new code.

All gains and the smoothing factor are unsigned fractions with 32 fractional bits, so the very small gains a long loop needs (a smoothing factor near 1/250, a proportional gain near 0.002, an integral gain near 1.3e-6) still fit. The filter state is held in 64-bit accumulators. One multiplier is shared across three consecutive cycles. A hold input lets the surrounding logic skip a sample without disturbing the loop. An integrator that stops accumulating while the output is clipped prevents windup.

Top module: `pi_loop_filter`

## Requirements
- R1: After reset, dacWord equals mid-scale (2^(DAC_W-1), 32768 by default) and dacValid is low. The filter state and the integrator start at zero.
- R2: The filter input is x = sampleErr + corrValue. Both are signed two's complement and sign-extended before the addition.
- R3: The smoothed state y, which carries F = 32 fractional bits, updates as y = y + floor(((x*2^F - y) * alphaCoef) / 2^F). alphaCoef is an unsigned fraction scaled by 2^F.
- R4: The proportional term is p = floor((y * kpCoef) / 2^F) and uses the y that was just updated.
- R5: The candidate integrator value is iNew = I + floor((y * kiCoef) / 2^F), using the updated y.
- R6: The output code is centerCode + floor((p + iNew) / 2^F), clamped to the range 0 to 2^DAC_W - 1.
- R7: When the clamp in R6 is active, the integrator keeps its previous value. Otherwise it takes iNew.
- R8: dacValid is high for exactly one cycle, at the 4th rising edge after the edge that accepts a sample. dacWord changes only on that edge.
- R9: A sample is accepted only when the block is idle and hold is low. A sampleValid pulse that arrives while a computation is in progress is ignored.
- R10: A sampleValid pulse with hold high changes neither the filter state nor the integrator, keeps dacWord, and produces no dacValid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | One-cycle pulse that presents a new error sample |
| sampleErr | input | ERR_W (24) | Signed timing-error sample |
| corrValue | input | CORR_W (16) | Signed correction added to the sample |
| hold | input | 1 | Causes the sample presented with it to be skipped |
| alphaCoef | input | COEF_W (32) | Low-pass factor, unsigned fraction scaled by 2^32 |
| kpCoef | input | COEF_W (32) | Proportional gain, unsigned fraction scaled by 2^32 |
| kiCoef | input | COEF_W (32) | Integral gain, unsigned fraction scaled by 2^32 |
| centerCode | input | DAC_W (16) | DAC code added to the controller output |
| dacWord | output | DAC_W (16) | DAC control code |
| dacValid | output | 1 | One-cycle strobe marking a new dacWord |

## Verification
The bench drives runs of large same-sign errors that push the code to full scale, then to zero, and then reverses direction. If the integrator kept accumulating while clipped, the code would stay pinned far longer than the reference and the first unclipped code would be wrong. Mixed-sign samples with non-zero corrections catch a design that drops the correction or extends it without its sign, because the smoothed value would then drift. A second pulse sent in mid-computation, and a pulse sent with hold high, catch a design that restarts its sequence or updates its state on a skipped sample: the next code would differ from the reference. The bench also counts cycles to each strobe, which catches any change in the pipeline depth.

// File: rtl/pi_loop_pkg.sv
package pi_loop_pkg;

  // Strobes from sequencer to datapath, at most one high per cycle.
  typedef struct packed {
    logic latchIn;   // capture sample + correction
    logic stepIir;   // low-pass update using shared multiplier
    logic capP;      // proportional product
    logic capI;      // integral product
    logic commit;    // clamp, write DAC word, update integrator
  } pi_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IIR,
    ST_PROP,
    ST_INTEG,
    ST_OUT
  } pi_state_t;

endpackage

// File: rtl/pi_loop_ctrl.sv
module pi_loop_ctrl
  import pi_loop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sampleValid,
  input  logic       hold,
  output pi_strobe_t strobe,
  output logic       busy
);

  pi_state_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (sampleValid && !hold) begin
          strobe.latchIn = 1'b1;
          stateNext      = ST_IIR;
        end
      end
      ST_IIR: begin
        strobe.stepIir = 1'b1;
        stateNext      = ST_PROP;
      end
      ST_PROP: begin
        strobe.capP = 1'b1;
        stateNext   = ST_INTEG;
      end
      ST_INTEG: begin
        strobe.capI = 1'b1;
        stateNext   = ST_OUT;
      end
      ST_OUT: begin
        strobe.commit = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pi_loop_dp.sv
module pi_loop_dp
  import pi_loop_pkg::*;
#(
  parameter int ERR_W  = 24,
  parameter int CORR_W = 16,
  parameter int COEF_W = 32,
  parameter int DAC_W  = 16,
  parameter int ACC_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  pi_strobe_t               strobe,
  input  logic signed [ERR_W-1:0]  sampleErr,
  input  logic signed [CORR_W-1:0] corrValue,
  input  logic [COEF_W-1:0]        alphaCoef,
  input  logic [COEF_W-1:0]        kpCoef,
  input  logic [COEF_W-1:0]        kiCoef,
  input  logic [DAC_W-1:0]         centerCode,
  output logic [DAC_W-1:0]         dacWord,
  output logic                     dacValid
);

  localparam int FRAC_W = COEF_W;
  localparam int PROD_W = ACC_W + COEF_W + 1;
  localparam logic signed [ACC_W-1:0] CODE_MAX = {{(ACC_W-DAC_W){1'b0}}, {DAC_W{1'b1}}};
  localparam logic [DAC_W-1:0] CODE_MID = {1'b1, {(DAC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] xFix, yAcc, pReg, iNew, integAcc;

  // Input: sign-extend both, add, scale into fixed point.
  logic signed [ACC_W-1:0] sampleExt, corrExt, sumIn;
  assign sampleExt = {{(ACC_W-ERR_W){sampleErr[ERR_W-1]}}, sampleErr};
  assign corrExt   = {{(ACC_W-CORR_W){corrValue[CORR_W-1]}}, corrValue};
  assign sumIn     = sampleExt + corrExt;

  // Shared multiplier: signed operand times unsigned fraction, rescaled.
  logic signed [ACC_W-1:0]  mulA;
  logic [COEF_W-1:0]        mulB;
  logic signed [PROD_W-1:0] aExt, bExt, prodFull, prodScaled;
  logic signed [ACC_W-1:0]  mulOut;

  always_comb begin
    mulA = '0;
    mulB = '0;
    if (strobe.stepIir) begin
      mulA = xFix - yAcc;
      mulB = alphaCoef;
    end else if (strobe.capP) begin
      mulA = yAcc;
      mulB = kpCoef;
    end else if (strobe.capI) begin
      mulA = yAcc;
      mulB = kiCoef;
    end
  end

  assign aExt       = {{(PROD_W-ACC_W){mulA[ACC_W-1]}}, mulA};
  assign bExt       = {{(PROD_W-COEF_W){1'b0}}, mulB};
  assign prodFull   = aExt * bExt;
  assign prodScaled = prodFull >>> FRAC_W;
  assign mulOut     = prodScaled[ACC_W-1:0];

  // Output stage: centre offset, clamp, anti-windup decision.
  logic signed [ACC_W-1:0] piSum, piInt, codeWide, centerExt;
  logic clipLo, clipHi;
  logic [DAC_W-1:0] codeSat;

  assign piSum     = pReg + iNew;
  assign piInt     = piSum >>> FRAC_W;
  assign centerExt = {{(ACC_W-DAC_W){1'b0}}, centerCode};
  assign codeWide  = piInt + centerExt;
  assign clipLo    = codeWide[ACC_W-1];
  assign clipHi    = !clipLo && (codeWide > CODE_MAX);

  always_comb begin
    if (clipLo)      codeSat = '0;
    else if (clipHi) codeSat = {DAC_W{1'b1}};
    else             codeSat = codeWide[DAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xFix     <= '0;
      yAcc     <= '0;
      pReg     <= '0;
      iNew     <= '0;
      integAcc <= '0;
      dacWord  <= CODE_MID;
      dacValid <= 1'b0;
    end else begin
      dacValid <= 1'b0;
      if (strobe.latchIn) xFix <= sumIn <<< FRAC_W;
      if (strobe.stepIir) yAcc <= yAcc + mulOut;
      if (strobe.capP)    pReg <= mulOut;
      if (strobe.capI)    iNew <= integAcc + mulOut;
      if (strobe.commit) begin
        dacWord  <= codeSat;
        dacValid <= 1'b1;
        if (!(clipLo || clipHi)) integAcc <= iNew;
      end
    end
  end

endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
  import pi_loop_pkg::*;
#(
  parameter int ERR_W  = 24,
  parameter int CORR_W = 16,
  parameter int COEF_W = 32,
  parameter int DAC_W  = 16,
  parameter int ACC_W  = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sampleValid,
  input  logic signed [ERR_W-1:0]  sampleErr,
  input  logic signed [CORR_W-1:0] corrValue,
  input  logic                     hold,
  input  logic [COEF_W-1:0]        alphaCoef,
  input  logic [COEF_W-1:0]        kpCoef,
  input  logic [COEF_W-1:0]        kiCoef,
  input  logic [DAC_W-1:0]         centerCode,
  output logic [DAC_W-1:0]         dacWord,
  output logic                     dacValid
);

  pi_strobe_t strobe;
  logic       busy;

  pi_loop_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .hold(hold),
    .strobe(strobe), .busy(busy)
  );

  pi_loop_dp #(
    .ERR_W(ERR_W), .CORR_W(CORR_W), .COEF_W(COEF_W), .DAC_W(DAC_W), .ACC_W(ACC_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .sampleErr(sampleErr), .corrValue(corrValue),
    .alphaCoef(alphaCoef), .kpCoef(kpCoef), .kiCoef(kiCoef),
    .centerCode(centerCode), .dacWord(dacWord), .dacValid(dacValid)
  );

endmodule

// File: rtl/pi_loop_chk.sv
module pi_loop_chk #(
  parameter int DAC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sampleValid,
  input logic             hold,
  input logic             busy,
  input logic             dacValid,
  input logic [DAC_W-1:0] dacWord
);

  // R8: strobe lasts one cycle
  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dacValid |=> !dacValid);

  // R8: word moves only together with the strobe
  assert_word_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dacWord) |-> dacValid);

  // R8: strobe ends a computation
  assert_strobe_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dacValid |-> ($past(busy) && !busy));

  // R9: a computation starts only from an accepted sample
  assert_start_accepted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sampleValid && !hold));

  // R10: a held sample does not start work
  assert_hold_skips_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleValid && hold && !busy) |=> !busy);

endmodule

bind pi_loop_filter pi_loop_chk #(.DAC_W(DAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .hold(hold),
  .busy(busy), .dacValid(dacValid), .dacWord(dacWord)
);

// File: tb/pi_loop_filter_tb_top.sv
`timescale 1ns/1ps
module pi_loop_filter_tb_top;

  localparam int ERR_W = 24, CORR_W = 16, COEF_W = 32, DAC_W = 16, ACC_W = 64;
  localparam int NVEC = 10;
  localparam int VEC_ERR  [NVEC] = '{100000, 50000, -20000, 0, 0, 3, -3, 70000, -65000, 12345};
  localparam int VEC_CORR [NVEC] = '{0, -1000, 500, 0, 250, 0, -7, 0, -300, 32767};

  logic clk = 0, rst_n = 0;
  logic sampleValid = 0, hold = 0;
  logic signed [ERR_W-1:0]  sampleErr = '0;
  logic signed [CORR_W-1:0] corrValue = '0;
  logic [COEF_W-1:0] alphaCoef, kpCoef, kiCoef;
  logic [DAC_W-1:0]  centerCode;
  logic [DAC_W-1:0]  dacWord;
  logic              dacValid;

  int errors = 0, checks = 0;
  bit finished = 0;

  // reference state
  logic signed [63:0] mY = 0, mI = 0;
  logic [15:0] mCode = 16'd32768;

  always #2 clk = ~clk;

  pi_loop_filter dut_i (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleErr(sampleErr),
    .corrValue(corrValue), .hold(hold), .alphaCoef(alphaCoef), .kpCoef(kpCoef),
    .kiCoef(kiCoef), .centerCode(centerCode), .dacWord(dacWord), .dacValid(dacValid)
  );

  function automatic logic signed [63:0] fxMul(logic signed [63:0] a, logic [31:0] c);
    logic signed [127:0] p;
    p = $signed({{64{a[63]}}, a}) * $signed({96'b0, c});
    return p[95:32];
  endfunction

  task automatic modelStep(int err, int corr);
    logic signed [63:0] x, p, iN, sh, cw;
    x  = (64'(signed'(err)) + 64'(signed'(corr))) <<< 32;       // R2
    mY = mY + fxMul(x - mY, alphaCoef);                          // R3
    p  = fxMul(mY, kpCoef);                                      // R4
    iN = mI + fxMul(mY, kiCoef);                                 // R5
    sh = (p + iN) >>> 32;
    cw = sh + 64'(centerCode);                                   // R6
    if (cw < 0)              mCode = 16'd0;
    else if (cw > 64'd65535) mCode = 16'hFFFF;
    else begin mCode = cw[15:0]; mI = iN; end                    // R7
  endtask

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one sample, return cycle index of strobe (0 if none)
  task automatic issue(int err, int corr, bit h, output int seen);
    @(negedge clk);
    sampleValid = 1; sampleErr = err[ERR_W-1:0]; corrValue = corr[CORR_W-1:0]; hold = h;
    @(posedge clk);
    @(negedge clk);
    sampleValid = 0; hold = 0;
    seen = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (dacValid && seen == 0) seen = k;
    end
  endtask

  task automatic stepAndCheck(int err, int corr, string req);
    int seen;
    issue(err, corr, 0, seen);
    modelStep(err, corr);
    check(seen == 4, "R8 latency", seen, 4);
    check(dacWord == mCode, req, dacWord, mCode);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seen;
    logic [15:0] keep;
    alphaCoef = 32'h4000_0000;  // 0.25
    kpCoef    = 32'h8000_0000;  // 0.5
    kiCoef    = 32'h1000_0000;  // 1/16
    centerCode = 16'd32768;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dacWord == 16'd32768, "R1 reset word", dacWord, 32768);
    check(dacValid == 0, "R1 reset strobe", dacValid, 0);
    rst_n = 1;

    // vector walk: R2..R6 on mixed-sign samples with corrections
    for (int v = 0; v < NVEC; v++) stepAndCheck(VEC_ERR[v], VEC_CORR[v], "R2/R3/R4/R5/R6 vector");

    // R10: held sample leaves everything untouched
    keep = dacWord;
    issue(90000, 100, 1, seen);
    check(seen == 0, "R10 no strobe", seen, 0);
    check(dacWord == keep, "R10 word kept", dacWord, keep);
    stepAndCheck(-4000, 0, "R10 state unchanged");

    // R9: second pulse during computation ignored
    @(negedge clk);
    sampleValid = 1; sampleErr = 24'sd30000; corrValue = 16'sd0;
    @(negedge clk); sampleValid = 0;
    @(negedge clk); sampleValid = 1; sampleErr = -24'sd800000;
    @(negedge clk); sampleValid = 0;
    repeat (6) @(negedge clk);
    modelStep(30000, 0);
    check(dacWord == mCode, "R9 busy pulse ignored", dacWord, mCode);
    stepAndCheck(0, 0, "R9 state after ignore");

    // R6/R7: drive into high clip, then low clip, then recover
    for (int k = 0; k < 5; k++) stepAndCheck(8000000, 0, "R6 clip high");
    check(dacWord == 16'hFFFF, "R6 full scale", dacWord, 65535);
    for (int k = 0; k < 6; k++) stepAndCheck(-8000000, 0, "R7 anti-windup low");
    check(dacWord == 16'h0000, "R6 zero scale", dacWord, 0);
    for (int k = 0; k < 8; k++) stepAndCheck(0, 0, "R7 recovery");

    // R3/R4/R5: slow loop coefficients, large centre shift
    alphaCoef = 32'd17179869;   // ~1/250
    kpCoef    = 32'd8589935;    // ~0.002
    kiCoef    = 32'd5583;       // ~1.3e-6
    centerCode = 16'd20000;
    for (int k = 0; k < 6; k++) stepAndCheck(2000000, -50, "R3 slow coefficients");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule